// File: doc/BRIEF.md
# Configuration-Space Window Bridge

This block is a slave on a big-endian processor bus. It claims one fixed, direct-mapped 4 MiB address window. Every access inside that window becomes a configuration request to bus 0 of a PCI hierarchy. The target device is not named by a binary field. It is picked by a one-hot device-select field inside the address: the lowest set bit of that field gives the device number. The function and register offset come from the lower address bits.

The processor side gives an address, a size code, write data and one-cycle read or write strobes. The block answers with a ready signal and read data. On the configuration side it issues a single-cycle request pulse. That pulse carries:
- the formed configuration address,
- byte enables,
- write data converted to little-endian lane order.

The block then waits for an acknowledge. For a read, the returned data is converted back to processor byte order. Each request address is built from its own access alone, and no state is kept from one access to the next.

Top module: `cfg_window_bridge`

## Requirements
- R1: Only accesses with address in [0x80800000, 0x80C00000) are claimed. Any other strobe produces no request and no error, and ready stays high.
- R2: The device number is the index of the lowest set bit among address bits 21..11, with bit 11 as index 0. If none of those bits is set, the device number is 11.
- R3: The configuration address has bit 31 = 1 and bits 30..16 = 0. Bits 15..8 hold devfn = (device << 3) | address[10:8]. Bits 7..2 equal address[7:2] and bits 1..0 are 0.
- R4: Size code 0 is a byte and sets byte enable 1 << addr[1:0]. Size code 1 is a halfword and sets 4'b0011 << addr[1:0]. Size code 2 is a word and sets 4'b1111.
- R5: The block returns an error instead of a request in these cases: a halfword with addr[0] = 1, a word with addr[1:0] != 0, size code 3, or read and write strobed together. The error is a one-cycle cpu_err pulse in the cycle after the strobe, and ready stays high.
- R6: Write data is right-justified. A byte passes unchanged. A halfword has its two low bytes swapped. A word has all four bytes reversed. Unused upper bits are zero.
- R7: Read data returned by the target is converted with the same per-size swap as R6. It appears on cpu_rdata in the cycle after the acknowledge. cpu_rdata is held until the next read completes.
- R8: An accepted strobe gives exactly one cfg_req pulse, in the cycle after the strobe. Ready is low from that cycle until the cycle after cfg_ack, and strobes seen while ready is low are ignored.
- R9: While reset is held, every output is zero, and an outstanding request is dropped. Ready goes high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Processor physical address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| cpu_wdata | input | 32 | Right-justified write data, processor byte order |
| cpu_rd | input | 1 | Read strobe (one cycle) |
| cpu_wr | input | 1 | Write strobe (one cycle) |
| cpu_rdata | output | 32 | Right-justified read data, processor byte order |
| cpu_ready | output | 1 | High when idle and able to accept a strobe |
| cpu_err | output | 1 | One-cycle error pulse for a rejected access |
| cfg_req | output | 1 | One-cycle configuration request pulse |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Formed configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data, little-endian lane order, right-justified |
| cfg_ack | input | 1 | Target completion acknowledge |
| cfg_rdata | input | 32 | Target read data, valid with cfg_ack |

## Verification
The bench builds the block with its default parameters: a window based at 0x80800000 spanning 2^22 bytes, and an 11-bit device-select field starting at address bit 11. With these values, every device outcome from 0 to 11 can be reached by random and directed addresses, including the empty-field result. Addresses just below and just above the window can also be produced from the same generator. Because the target acknowledge delay varies from zero to three cycles, strobes that arrive while the block is busy and a reset that lands during an outstanding request can both be exercised.

// File: rtl/cfgw_pkg.sv
// Shared types for the configuration window bridge.
// Assumes: size codes are fixed by the processor bus encoding.
package cfgw_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } brg_state_e;
endpackage

// File: rtl/cfgw_addr_decode.sv
// Address decoder: checks the window, picks the device from the one-hot
// select field, builds the configuration address and byte enables,
// and flags alignment faults.
// Assumes: DEV_W + 3 <= 8 so devfn fits its byte; the window is a power of two.
module cfgw_addr_decode
    import cfgw_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
    parameter int          WIN_LOG2  = 22,
    parameter int          SEL_LO    = 11,
    parameter int          SEL_N     = 11
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          hit,
    output logic          misalign,
    output logic [31:0]   cfg_addr,
    output logic [3:0]    be
);
    localparam int DEV_W = $clog2(SEL_N + 1);

    logic [SEL_N-1:0] sel;
    logic [DEV_W-1:0] dev;
    logic [7:0]       devfn;

    assign sel = addr[SEL_LO +: SEL_N];
    assign hit = (addr[AW-1:WIN_LOG2] == WIN_BASE[AW-1:WIN_LOG2]);

    // Priority scan: lowest set select bit wins, none gives SEL_N.
    always_comb begin
        dev = DEV_W'(SEL_N);
        for (int i = SEL_N - 1; i >= 0; i--) begin
            if (sel[i]) dev = DEV_W'(i);
        end
    end

    assign devfn    = 8'({dev, addr[10:8]});
    assign cfg_addr = {1'b1, 15'd0, devfn, addr[7:2], 2'b00};

    // Byte enables and alignment check from size and low address bits.
    always_comb begin
        be       = 4'b0000;
        misalign = 1'b0;
        case (acc_size_e'(size))
            SZ_BYTE: be = 4'b0001 << addr[1:0];
            SZ_HALF: begin
                be       = 4'b0011 << addr[1:0];
                misalign = addr[0];
            end
            SZ_WORD: begin
                be       = 4'b1111;
                misalign = (addr[1:0] != 2'b00);
            end
            default: misalign = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfgw_lane_swap.sv
// Byte-lane converter between big-endian processor order and
// little-endian configuration order for right-justified data.
// Assumes: DW is a multiple of 8 and at least 32; sizes above word are invalid.
module cfgw_lane_swap
    import cfgw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int WB = 4;
    localparam int HB = 2;

    logic [8*WB-1:0] word_rev;
    logic [8*HB-1:0] half_rev;

    // Reverse the bytes of the word and of the low halfword.
    for (genvar g = 0; g < WB; g++) begin : g_word
        assign word_rev[8*g +: 8] = din[8*(WB-1-g) +: 8];
    end
    for (genvar g = 0; g < HB; g++) begin : g_half
        assign half_rev[8*g +: 8] = din[8*(HB-1-g) +: 8];
    end

    // Select the swapped form for the access size, zeroing unused lanes.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: dout = DW'(din[7:0]);
            SZ_HALF: dout = DW'(half_rev);
            SZ_WORD: dout = DW'(word_rev);
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/cfg_window_bridge.sv
// Top of the configuration window bridge: accepts processor strobes,
// issues one configuration request per good access, and waits for the
// target acknowledge before it reports ready again.
// Assumes: strobes last one cycle; cfg_ack arrives once per request.
module cfg_window_bridge
    import cfgw_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_LOG2 = 22,
    parameter int          SEL_LO   = 11,
    parameter int          SEL_N    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_size,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          cpu_err,
    output logic          cfg_req,
    output logic          cfg_we,
    output logic [31:0]   cfg_addr,
    output logic [3:0]    cfg_be,
    output logic [DW-1:0] cfg_wdata,
    input  logic          cfg_ack,
    input  logic [DW-1:0] cfg_rdata
);
    brg_state_e    state;
    logic [1:0]    size_q;
    logic          hit, misalign, bad, strobe;
    logic [31:0]   dec_addr;
    logic [3:0]    dec_be;
    logic [DW-1:0] wr_swapped, rd_swapped;

    cfgw_addr_decode #(
        .AW(AW), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
        .SEL_LO(SEL_LO), .SEL_N(SEL_N)
    ) i_dec (
        .addr(cpu_addr), .size(cpu_size), .hit(hit),
        .misalign(misalign), .cfg_addr(dec_addr), .be(dec_be)
    );

    cfgw_lane_swap #(.DW(DW)) i_wswap (
        .size(cpu_size), .din(cpu_wdata), .dout(wr_swapped)
    );

    cfgw_lane_swap #(.DW(DW)) i_rswap (
        .size(size_q), .din(cfg_rdata), .dout(rd_swapped)
    );

    assign strobe = cpu_rd | cpu_wr;
    assign bad    = misalign | (cpu_rd & cpu_wr);

    // Request sequencer: accept, issue, wait for acknowledge, return data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            size_q    <= 2'd0;
            cpu_rdata <= '0;
            cpu_ready <= 1'b0;
            cpu_err   <= 1'b0;
            cfg_req   <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_addr  <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
        end else begin
            cfg_req <= 1'b0;
            cpu_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cpu_ready <= 1'b1;
                    if (strobe && hit && cpu_ready) begin
                        if (bad) begin
                            cpu_err <= 1'b1;
                        end else begin
                            cfg_req   <= 1'b1;
                            cfg_we    <= cpu_wr;
                            cfg_addr  <= dec_addr;
                            cfg_be    <= dec_be;
                            cfg_wdata <= cpu_wr ? wr_swapped : '0;
                            size_q    <= cpu_size;
                            cpu_ready <= 1'b0;
                            state     <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (cfg_ack) begin
                        if (!cfg_we) cpu_rdata <= rd_swapped;
                        cpu_ready <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> !cfg_req); // R8
    AST_REQ_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !cpu_ready); // R8
    AST_ACK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && cfg_ack) |=> cpu_ready); // R8
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (!cfg_req && cpu_ready)); // R5
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_addr[31] && cfg_addr[30:16] == 15'd0 && cfg_addr[1:0] == 2'b00)); // R3
    AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_addr[15:11] <= 5'(SEL_N))); // R2
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                     cfg_be == 4'b1100 || cfg_be == 4'b1111)); // R4
endmodule

// File: tb/test_cfg_window_bridge.sv
module test_cfg_window_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, cpu_err;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0, fails = 0, cycles = 0, req_cnt = 0;
    logic [31:0] last_rd = '0;

    cfg_window_bridge i_cfg_window_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cfg_req) req_cnt <= req_cnt + 1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) if (cycles > 150000) begin
        checks = checks + 1; fails = fails + 1;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        summary();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_dev(logic [31:0] a);
        for (int i = 0; i < 11; i++) if (a[11+i]) return 4'(i);
        return 4'd11;
    endfunction

    function automatic logic [31:0] exp_cfg(logic [31:0] a);
        logic [7:0] df;
        df = {1'b0, exp_dev(a), a[10:8]};
        return {1'b1, 15'd0, df, a[7:2], 2'b00};
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            2'd0: return 4'b0001 << lo;
            2'd1: return 4'b0011 << lo;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic exp_bad(logic [1:0] sz, logic [1:0] lo, logic rd, logic wr);
        return (sz == 2'd3) || (sz == 2'd1 && lo[0]) || (sz == 2'd2 && lo != 2'd0) || (rd && wr);
    endfunction

    function automatic logic [31:0] exp_swap(logic [1:0] sz, logic [31:0] d);
        case (sz)
            2'd0: return {24'd0, d[7:0]};
            2'd1: return {16'd0, d[7:0], d[15:8]};
            2'd2: return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return 32'd0;
        endcase
    endfunction

    // One processor access with a target model acknowledging after dly cycles.
    task automatic access(logic [31:0] a, logic [1:0] sz, logic rd, logic wr,
                          logic [31:0] wd, logic [31:0] resp, int dly, bit poke_busy);
        int rc0;
        logic hit;
        hit = (a[31:22] == 10'h202);
        rc0 = req_cnt;
        @(negedge clk);
        cpu_addr = a; cpu_size = sz; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        if (!hit) begin
            chk("R1 req", {31'd0, cfg_req}, 32'd0);
            chk("R1 err", {31'd0, cpu_err}, 32'd0);
            chk("R1 ready", {31'd0, cpu_ready}, 32'd1);
        end else if (exp_bad(sz, a[1:0], rd, wr)) begin
            chk("R5 err", {31'd0, cpu_err}, 32'd1);
            chk("R5 req", {31'd0, cfg_req}, 32'd0);
            chk("R5 ready", {31'd0, cpu_ready}, 32'd1);
            @(negedge clk);
            chk("R5 err pulse", {31'd0, cpu_err}, 32'd0);
        end else begin
            chk("R8 req", {31'd0, cfg_req}, 32'd1);
            chk("R8 ready low", {31'd0, cpu_ready}, 32'd0);
            chk("R2/R3 addr", cfg_addr, exp_cfg(a));
            chk("R4 be", {28'd0, cfg_be}, {28'd0, exp_be(sz, a[1:0])});
            chk("R8 we", {31'd0, cfg_we}, {31'd0, wr});
            if (wr) chk("R6 wdata", cfg_wdata, exp_swap(sz, wd));
            if (poke_busy) begin
                cpu_addr = 32'h8080_0800; cpu_size = 2'd2; cpu_rd = 1'b1;
            end
            for (int k = 0; k < dly; k++) @(negedge clk);
            chk("R8 busy", {31'd0, cpu_ready}, 32'd0);
            cpu_rd = 1'b0;
            cfg_ack = 1'b1; cfg_rdata = resp;
            @(negedge clk);
            cfg_ack = 1'b0; cfg_rdata = 32'hDEAD_BEEF;
            chk("R8 ready back", {31'd0, cpu_ready}, 32'd1);
            if (rd) last_rd = exp_swap(sz, resp);
            chk("R7 rdata", cpu_rdata, last_rd);
            @(negedge clk);
            chk("R8 one req", 32'(req_cnt - rc0), 32'd1);
        end
    endtask

    function automatic logic [31:0] rand_addr();
        logic [31:0] a;
        int m;
        a = 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
        m = $urandom_range(0, 5);
        if (m < 3) a[21:11] = 11'(1) << $urandom_range(0, 10);
        else if (m == 3) a[21:11] = '0;
        else if (m == 4) a = ($urandom_range(0, 1) != 0) ? 32'h807F_FFFC - ($urandom & 32'hFFC) : 32'h80C0_0000 + ($urandom & 32'hFFFC);
        return a;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: outputs zero while reset is held
        chk("R9 rst outs", {cpu_rdata | cfg_addr | cfg_wdata}, 32'd0);
        chk("R9 rst ctl", {26'd0, cpu_ready, cpu_err, cfg_req, cfg_we, 2'b0} | {28'd0, cfg_be}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready after reset", {31'd0, cpu_ready}, 32'd1);

        // Directed: no select bit -> device 11 (R2), top select bit, boundaries (R1)
        access(32'h8080_0704, 2'd2, 1'b1, 1'b0, 0, 32'h1122_3344, 0, 0);
        access(32'h80A0_0306, 2'd1, 1'b0, 1'b1, 32'h0000_A1B2, 0, 2, 0);
        access(32'h8080_1803, 2'd0, 1'b0, 1'b1, 32'hFFFF_FF5A, 0, 1, 0);
        access(32'h807F_FFFC, 2'd2, 1'b1, 1'b0, 0, 0, 0, 0);
        access(32'h80C0_0000, 2'd2, 1'b1, 1'b0, 0, 0, 0, 0);
        access(32'h80BF_FFFC, 2'd2, 1'b1, 1'b0, 0, 32'hCAFE_F00D, 3, 1);
        // R5: misaligned, bad size, both strobes
        access(32'h8080_0802, 2'd2, 1'b1, 1'b0, 0, 0, 0, 0);
        access(32'h8080_0801, 2'd1, 1'b0, 1'b1, 0, 0, 0, 0);
        access(32'h8080_0800, 2'd3, 1'b1, 1'b0, 0, 0, 0, 0);
        access(32'h8080_0800, 2'd2, 1'b1, 1'b1, 0, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            logic [1:0] sz;
            logic [31:0] a;
            logic r;
            a = rand_addr();
            sz = 2'($urandom_range(0, 2));
            if ($urandom_range(0, 7) != 0) begin
                if (sz == 2'd1) a[0] = 1'b0;
                if (sz == 2'd2) a[1:0] = 2'b00;
            end
            r = 1'($urandom_range(0, 1));
            access(a, sz, r, !r, $urandom, $urandom, $urandom_range(0, 3), 1'($urandom_range(0, 1)));
        end

        // R9: reset during an outstanding request
        @(negedge clk);
        cpu_addr = 32'h8080_4000; cpu_size = 2'd2; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        chk("R9 pre req", {31'd0, cfg_req}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid rst", cpu_rdata | cfg_addr | {27'd0, cpu_ready, cpu_err, cfg_req, cfg_we, 1'b0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready", {31'd0, cpu_ready}, 32'd1);
        last_rd = '0;
        access(32'h8080_0004, 2'd0, 1'b1, 1'b0, 0, 32'h0000_0077, 1, 0);
        summary();
    end
endmodule